// File: doc/BRIEF.md
# Paged and Pointer-Based Data Address Generator

This block forms the 16-bit data-memory operand address for a small DSP-style core. It supports two modes. In paged (direct) mode, a 9-bit page register supplies the upper address bits and a 7-bit offset from the instruction word supplies the lower bits. This divides data memory into 512 pages of 128 words. In pointer (indirect) mode, the address is the contents of one of eight 16-bit pointer registers. A separate 3-bit select register picks which pointer register is used.

The core loads the page register, any pointer register and the select register through one shared write-data bus, with a strobe for each target. The address output is combinational from the mode input, the offset input and the current register contents. A write therefore changes the address only from the cycle after its strobe. A valid flag follows the request input, and the address is forced to zero when no request is present.

Top module: `dag_addr_gen`

## Requirements
- R1: After reset the page register, all eight pointer registers and the select register are zero.
- R2: With req_i high and mode_i = 0 (paged), addr_o = {page register, offset_i}, with the page in bits 15:7 and the offset in bits 6:0.
- R3: A page write (page_we_i) loads wdata_i[8:0] into the page register, and wdata_i[15:9] is ignored.
- R4: With req_i high and mode_i = 1 (pointer), addr_o equals pointer register n, where n is the value of the select register.
- R5: A pointer write (ptr_we_i) loads all 16 bits of wdata_i into the pointer register numbered ptr_idx_i, and the other seven registers are unchanged.
- R6: A select write (sel_we_i) loads wdata_i[2:0] into the select register, and wdata_i[15:3] is ignored.
- R7: Every write takes effect at the next rising clock edge. addr_o in the cycle of the strobe still reflects the old register contents.
- R8: valid_o equals req_i. While req_i is low, addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request |
| mode_i | input | 1 | 0 = paged, 1 = pointer |
| offset_i | input | 7 | Offset field from the instruction word |
| wdata_i | input | 16 | Shared register write data |
| page_we_i | input | 1 | Page register write strobe |
| ptr_we_i | input | 1 | Pointer register write strobe |
| ptr_idx_i | input | 3 | Pointer register written by ptr_we_i |
| sel_we_i | input | 1 | Select register write strobe |
| addr_o | output | 16 | Operand address |
| valid_o | output | 1 | Address valid |

## Verification
addr_o and valid_o are combinational, so they are due in the same cycle as the mode, offset and request inputs. A register write shows up only one rising edge after its strobe. The bench drives each vector on the falling edge and compares the output shortly afterwards, against a model that still holds the pre-edge register contents. It updates its model for any strobed write only after the next rising edge. This ordering checks both the zero-latency address path and the one-cycle write latency in every vector.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned PAGE_W = 9;
  localparam int unsigned OFS_W  = 7;
  localparam int unsigned ADDR_W = PAGE_W + OFS_W;
  localparam int unsigned PTR_N  = 8;
  localparam int unsigned SEL_W  = $clog2(PTR_N);

  typedef enum logic {
    MODE_PAGED   = 1'b0,
    MODE_POINTER = 1'b1
  } dag_mode_e;
endpackage

// File: rtl/dag_field_reg.sv
module dag_field_reg #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FLD_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [FLD_W-1:0]  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i[FLD_W-1:0];
  end

  p_field_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i[FLD_W-1:0]));
  p_field_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_N  = 8,
  localparam int unsigned IDX_W = $clog2(PTR_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [PTR_N];

  for (genvar g = 0; g < PTR_N; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))        regs_q[g] <= wdata_i;
    end

    p_ptr_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && widx_i == IDX_W'(g)) |=> $stable(regs_q[g]));
  end

  assign rdata_o = regs_q[ridx_i];

  p_ptr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ridx_i == widx_i) ##1 $stable(ridx_i) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
  import dag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              mode_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              page_we_i,
  input  logic              ptr_we_i,
  input  logic [SEL_W-1:0]  ptr_idx_i,
  input  logic              sel_we_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic [PAGE_W-1:0] page_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ptr_rdata;
  dag_mode_e         mode;

  dag_field_reg #(.DATA_W(ADDR_W), .FLD_W(PAGE_W)) i_page (
    .clk_i, .rst_ni, .we_i(page_we_i), .wdata_i, .q_o(page_q)
  );

  dag_field_reg #(.DATA_W(ADDR_W), .FLD_W(SEL_W)) i_sel (
    .clk_i, .rst_ni, .we_i(sel_we_i), .wdata_i, .q_o(sel_q)
  );

  dag_ptr_file #(.DATA_W(ADDR_W), .PTR_N(PTR_N)) i_ptrs (
    .clk_i, .rst_ni, .we_i(ptr_we_i), .widx_i(ptr_idx_i), .wdata_i,
    .ridx_i(sel_q), .rdata_o(ptr_rdata)
  );

  assign mode = dag_mode_e'(mode_i);

  always_comb begin
    addr_o = '0;
    if (req_i) begin
      unique case (mode)
        MODE_PAGED:   addr_o = {page_q, offset_i};
        MODE_POINTER: addr_o = ptr_rdata;
        default:      addr_o = '0;
      endcase
    end
  end

  assign valid_o = req_i;

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> addr_o == '0);
  p_page_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(page_we_i) && req_i && !mode_i |-> addr_o[ADDR_W-1:OFS_W] == $past(wdata_i[PAGE_W-1:0]));
  p_sel_path_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> sel_q == $past(wdata_i[SEL_W-1:0]));
endmodule

// File: tb/test_dag_addr_gen.sv
module test_dag_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, mode = 1'b0, page_we = 1'b0, ptr_we = 1'b0, sel_we = 1'b0;
  logic [6:0]  ofs = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  pidx = '0;
  logic [15:0] addr;
  logic        valid;

  int n_vec = 0, n_bad = 0;
  logic [8:0]  m_page;
  logic [2:0]  m_sel;
  logic [15:0] m_ptr [8];

  always #4 clk = ~clk;

  dag_addr_gen i_dag_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .offset_i(ofs),
    .wdata_i(wdata), .page_we_i(page_we), .ptr_we_i(ptr_we), .ptr_idx_i(pidx),
    .sel_we_i(sel_we), .addr_o(addr), .valid_o(valid)
  );

  function automatic logic [15:0] expect_addr();
    if (!req) return 16'h0;
    return mode ? m_ptr[m_sel] : {m_page, ofs};
  endfunction

  // Check the current vector against the pre-edge model (R7), then clock it in.
  task automatic step(input string tag);
    logic [15:0] e;
    #1;
    e = expect_addr();
    n_vec++;
    if (addr !== e || valid !== req) begin
      n_bad++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", tag, addr, valid, e, req);
    end
    @(posedge clk);
    if (page_we) m_page = wdata[8:0];
    if (sel_we)  m_sel  = wdata[2:0];
    if (ptr_we)  m_ptr[pidx] = wdata;
    @(negedge clk);
    page_we = 1'b0; ptr_we = 1'b0; sel_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_page = '0; m_sel = '0;
    for (int i = 0; i < 8; i++) m_ptr[i] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state visible in both modes
    req = 1'b1; mode = 1'b0; ofs = 7'h55; step("R1 page");
    mode = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sel_we = 1'b1; wdata = 16'(i); mode = 1'b1; step("R1 ptr");
    end
    sel_we = 1'b1; wdata = 16'h0; step("R6 sel");

    // R2 R3 R7: every page value, junk upper bits, offsets swept
    mode = 1'b0;
    for (int p = 0; p < 512; p++) begin
      page_we = 1'b1; wdata = 16'(p) | 16'hFE00; ofs = 7'(p * 37);
      step("R3 page write same cycle");
      ofs = 7'(p * 11 + 3); step("R2 paged addr");
    end
    for (int o = 0; o < 128; o++) begin ofs = 7'(o); step("R2 offset sweep"); end

    // R5: load each pointer register, others must hold
    for (int i = 0; i < 8; i++) begin
      ptr_we = 1'b1; pidx = 3'(i); wdata = 16'hA000 ^ 16'(i * 16'h1357);
      mode = 1'(i & 1); step("R5 ptr write");
    end

    // R4 R6: sweep the select register with junk upper bits
    mode = 1'b1;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 8; i++) begin
        sel_we = 1'b1; wdata = 16'hFFF8 | 16'(i); step("R6 sel write same cycle");
        step("R4 pointer addr");
      end
    end

    // R5 R7: rewrite the selected pointer, old value seen until the edge
    sel_we = 1'b1; wdata = 16'h5; step("R6 sel");
    for (int v = 0; v < 64; v++) begin
      ptr_we = 1'b1; pidx = 3'(v); wdata = 16'(v * 1021 + 7);
      step("R5 R7 ptr rewrite");
      step("R4 after rewrite");
    end

    // R8: no request gives zero address and low valid
    for (int i = 0; i < 16; i++) begin
      req = 1'b0; mode = 1'(i); ofs = 7'(i * 9); step("R8 idle");
    end
    req = 1'b1; mode = 1'b0; step("R8 resume");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule